// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block is a register of `WIDTH` bits (eight by default) that changes state only on the rising clock edge. On each edge it either keeps its value, shifts towards the high end, shifts towards the low end, loads a word from a parallel port, or clears. A two-bit mode input selects the operation. An active-low synchronous clear takes priority over the mode.

The parallel port is bidirectional in the system. Here it is modelled as three separate signals: an input word, an output word that always shows the register contents, and an output-enable flag. The enable is true only when both active-low enable inputs are low and the block is not in load mode. The port therefore turns itself around when a load is requested. Turning the driver off never stops the register from working.

The lowest and highest bits are always visible on dedicated serial outputs, and each end has its own serial input. Two or more instances can therefore be chained into a longer shift register: the high serial output of one stage feeds the low serial input of the next, and the next stage's low serial output feeds back into the high serial input.

Top module: `uni_shift_reg`

## Requirements
- R1: With `modeSel` = 2'b00 and `rstSyncN` high, the register keeps its value across the clock edge.
- R2: With `modeSel` = 2'b01 and `rstSyncN` high, bit 0 takes `serInLow` and each bit n takes the old bit n-1 on the edge.
- R3: With `modeSel` = 2'b10 and `rstSyncN` high, bit WIDTH-1 takes `serInHigh` and each bit n takes the old bit n+1 on the edge.
- R4: With `modeSel` = 2'b11 and `rstSyncN` high, the register takes the value of `ioIn` on the edge.
- R5: While `rstSyncN` is low, the next rising edge clears every bit to 0, whatever `modeSel` holds.
- R6: `ioOe` is 1 exactly when `oeAN` and `oeBN` are both 0 and `modeSel` is not 2'b11.
- R7: `ioOut` always equals the register contents, whatever the enables and the mode are.
- R8: Hold, shift, load and clear behave the same when `oeAN` or `oeBN` is high as when the port is driven.
- R9: `serOutLow` always equals bit 0 and `serOutHigh` always equals bit WIDTH-1 of the register.
- R10: Two instances chained (the high serial output of the lower stage feeds the low serial input of the upper stage, and the low serial output of the upper stage feeds the high serial input of the lower stage), with shared mode, clear and clock, behave as one register of 2*WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstSyncN | input | 1 | Active-low synchronous clear, overrides the mode |
| modeSel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| oeAN | input | 1 | Active-low port enable, first of two |
| oeBN | input | 1 | Active-low port enable, second of two |
| serInLow | input | 1 | Serial bit entering bit 0 on an upward shift |
| serInHigh | input | 1 | Serial bit entering bit WIDTH-1 on a downward shift |
| ioIn | input | WIDTH | Word sampled from the shared port in load mode |
| ioOut | output | WIDTH | Register contents offered to the shared port |
| ioOe | output | 1 | Driver enable for the shared port |
| serOutLow | output | 1 | Bit 0 of the register |
| serOutHigh | output | 1 | Bit WIDTH-1 of the register |

## Verification
The assertions assume that the mode, clear and serial inputs are settled at each rising edge. They also assume that `rstSyncN` is driven to a known level from the first edge, because the clear property has no reset to hide behind. The bench changes every input only on the falling edge and applies a clear in the first cycle. It then mixes random modes, clears and enable pairs on a two-stage chain, so the enable pair is sometimes high during loads and shifts. The random sequence is seeded once so that a run can be repeated.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHUP = 2'b01,
    MODE_SHDN = 2'b10,
    MODE_LOAD = 2'b11
  } modeT;

  // one-hot operation strobes plus the port drive flag
  typedef struct packed {
    logic clr;
    logic shUp;
    logic shDn;
    logic ld;
    logic drive;
  } strobeT;

endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
(
  input  logic       clk,
  input  logic       rstSyncN,
  input  logic [1:0] modeSel,
  input  logic       oeAN,
  input  logic       oeBN,
  output strobeT     strb
);

  modeT modeCur;

  always_comb begin
    modeCur    = modeT'(modeSel);
    strb       = '0;
    if (!rstSyncN) begin
      strb.clr = 1'b1;
    end else begin
      unique case (modeCur)
        MODE_SHUP: strb.shUp = 1'b1;
        MODE_SHDN: strb.shDn = 1'b1;
        MODE_LOAD: strb.ld   = 1'b1;
        default:   ;
      endcase
    end
    strb.drive = !oeAN && !oeBN && (modeCur != MODE_LOAD);
  end

  // R5: at most one register operation per edge
  one_op_chk: assert property (@(posedge clk)
    $onehot0({strb.clr, strb.shUp, strb.shDn, strb.ld}));

  // R6
  load_no_drive_chk: assert property (@(posedge clk) disable iff (!rstSyncN)
    strb.ld |-> !strb.drive);

  // R6
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rstSyncN)
    strb.drive |-> (!oeAN && !oeBN));

endmodule

// File: rtl/usr_datapath.sv
module usr_datapath
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  strobeT           strb,
  input  logic             serInLow,
  input  logic             serInHigh,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] dataQ
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromBelow;
    logic fromAbove;
    if (i == 0) begin : g_lo
      assign fromBelow = serInLow;
    end else begin : g_lo
      assign fromBelow = dataQ[i-1];
    end
    if (i == TOP) begin : g_hi
      assign fromAbove = serInHigh;
    end else begin : g_hi
      assign fromAbove = dataQ[i+1];
    end
    always_comb begin
      if (strb.clr)       nextQ[i] = 1'b0;
      else if (strb.ld)   nextQ[i] = parIn[i];
      else if (strb.shUp) nextQ[i] = fromBelow;
      else if (strb.shDn) nextQ[i] = fromAbove;
      else                nextQ[i] = dataQ[i];
    end
  end

  always_ff @(posedge clk) begin
    dataQ <= nextQ;
  end

  // R5
  clr_zero_chk: assert property (@(posedge clk)
    strb.clr |=> (dataQ == '0));

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (strb.clr)
    !(strb.shUp || strb.shDn || strb.ld) |=> $stable(dataQ));

  // R2
  shift_up_chk: assert property (@(posedge clk) disable iff (strb.clr)
    strb.shUp |=> (dataQ == {$past(dataQ[TOP-1:0]), $past(serInLow)}));

  // R3
  shift_dn_chk: assert property (@(posedge clk) disable iff (strb.clr)
    strb.shDn |=> (dataQ == {$past(serInHigh), $past(dataQ[TOP:1])}));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (strb.clr)
    strb.ld |=> (dataQ == $past(parIn)));

endmodule

// File: rtl/uni_shift_reg.sv
module uni_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstSyncN,
  input  logic [1:0]       modeSel,
  input  logic             oeAN,
  input  logic             oeBN,
  input  logic             serInLow,
  input  logic             serInHigh,
  input  logic [WIDTH-1:0] ioIn,
  output logic [WIDTH-1:0] ioOut,
  output logic             ioOe,
  output logic             serOutLow,
  output logic             serOutHigh
);

  strobeT           strb;
  logic [WIDTH-1:0] regQ;

  usr_ctrl u_ctrl (
    .clk      (clk),
    .rstSyncN (rstSyncN),
    .modeSel  (modeSel),
    .oeAN     (oeAN),
    .oeBN     (oeBN),
    .strb     (strb)
  );

  usr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .strb      (strb),
    .serInLow  (serInLow),
    .serInHigh (serInHigh),
    .parIn     (ioIn),
    .dataQ     (regQ)
  );

  assign ioOut      = regQ;
  assign ioOe       = strb.drive;
  assign serOutLow  = regQ[0];
  assign serOutHigh = regQ[WIDTH-1];

  // R5: port-level view of the clear
  port_clear_chk: assert property (@(posedge clk)
    !rstSyncN |=> (ioOut == '0));

  // R8: loads go ahead with the port disabled
  load_while_off_chk: assert property (@(posedge clk) disable iff (!rstSyncN)
    (modeSel == 2'b11 && (oeAN || oeBN)) |=> (ioOut == $past(ioIn)));

endmodule

// File: tb/tb_uni_shift_reg.sv
module tb_uni_shift_reg;

  localparam int W  = 8;
  localparam int W2 = 2 * W;

  logic          clk = 1'b0;
  logic          rstSyncN = 1'b0;
  logic [1:0]    modeSel = 2'b00;
  logic          oeAN = 1'b1;
  logic          oeBN = 1'b1;
  logic          chainInLow = 1'b0;
  logic          chainInHigh = 1'b0;
  logic [W2-1:0] busIn = '0;

  logic [W-1:0]  outLo, outHi;
  logic          oeLo, oeHi;
  logic          sLoLo, sHiLo, sLoHi, sHiHi;

  int total = 0;
  int bad   = 0;
  logic [W2-1:0] model = '0;

  always #2 clk = ~clk;

  // lower stage
  uni_shift_reg #(.WIDTH(W)) dut (
    .clk(clk), .rstSyncN(rstSyncN), .modeSel(modeSel),
    .oeAN(oeAN), .oeBN(oeBN),
    .serInLow(chainInLow), .serInHigh(sLoHi),
    .ioIn(busIn[W-1:0]), .ioOut(outLo), .ioOe(oeLo),
    .serOutLow(sLoLo), .serOutHigh(sHiLo)
  );

  // upper stage, chained for R10
  uni_shift_reg #(.WIDTH(W)) dutHi (
    .clk(clk), .rstSyncN(rstSyncN), .modeSel(modeSel),
    .oeAN(oeAN), .oeBN(oeBN),
    .serInLow(sHiLo), .serInHigh(chainInHigh),
    .ioIn(busIn[W2-1:W]), .ioOut(outHi), .ioOe(oeHi),
    .serOutLow(sLoHi), .serOutHigh(sHiHi)
  );

  function automatic logic [W2-1:0] nextModel(
      input logic [W2-1:0] cur, input logic rN, input logic [1:0] m,
      input logic [W2-1:0] din, input logic sLo, input logic sHi);
    if (!rN) return '0;
    case (m)
      2'b01:   return {cur[W2-2:0], sLo};
      2'b10:   return {sHi, cur[W2-1:1]};
      2'b11:   return din;
      default: return cur;
    endcase
  endfunction

  function automatic logic expOe(input logic a, input logic b, input logic [1:0] m);
    return !a && !b && (m != 2'b11);
  endfunction

  function automatic string tagFor(input logic rN, input logic [1:0] m,
                                   input logic a, input logic b);
    string t;
    if (!rN) t = "R5";
    else case (m)
      2'b00:   t = "R1";
      2'b01:   t = "R2";
      2'b10:   t = "R3";
      default: t = "R4";
    endcase
    if (a || b) t = {t, "/R7/R8"};
    return {t, "/R10"};
  endfunction

  task automatic check(input string tag, input logic [W2-1:0] got, input logic [W2-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one cycle: drive at falling edge, check enables, clock, check state
  task automatic step(input logic rN, input logic [1:0] m, input logic a,
                      input logic b, input logic [W2-1:0] din,
                      input logic sLo, input logic sHi);
    @(negedge clk);
    rstSyncN = rN; modeSel = m; oeAN = a; oeBN = b;
    busIn = din; chainInLow = sLo; chainInHigh = sHi;
    #1;
    // R6
    check("R6", {14'd0, oeHi, oeLo}, {14'd0, expOe(a, b, m), expOe(a, b, m)});
    model = nextModel(model, rN, m, din, sLo, sHi);
    @(posedge clk);
    #1;
    check(tagFor(rN, m, a, b), {outHi, outLo}, model);
    // R9
    check("R9", {12'd0, sHiHi, sLoHi, sHiLo, sLoLo},
          {12'd0, model[W2-1], model[W], model[W-1], model[0]});
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    // reset state (R5)
    step(1'b0, 2'b11, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1);
    // R4 load with port enabled; R6 must show no drive
    step(1'b1, 2'b11, 1'b0, 1'b0, 16'hA55A, 1'b0, 1'b0);
    // R1 hold with changing inputs
    step(1'b1, 2'b00, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b1);
    // R2 / R10: upward shift carries bit 7 across the stage boundary
    step(1'b1, 2'b11, 1'b0, 1'b0, 16'h0080, 1'b0, 1'b0);
    step(1'b1, 2'b01, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0);
    // R3 / R10: downward shift carries bit 8 back across
    step(1'b1, 2'b10, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1);
    step(1'b1, 2'b10, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
    // R7 / R8: port disabled, operations still take effect
    step(1'b1, 2'b11, 1'b1, 1'b0, 16'hC3E1, 1'b0, 1'b0);
    step(1'b1, 2'b01, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0);
    step(1'b1, 2'b10, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b1);
    // R5: clear overrides a shift while the port is disabled
    step(1'b0, 2'b01, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic rN;
      rN = ($urandom % 16) != 0;
      step(rN, 2'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
           16'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule